// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits between instruction decode and the two integer pipes of an in-order, dual-issue core. Each clock it looks at the two oldest decoded instructions in the instruction buffer. The older one always goes to the full-function U pipe. The younger one may issue beside it in the restricted V pipe, but only when every pairing rule allows it. The rules cover the pairability class, register hazards between the two, an instruction that carries both a displacement and an immediate, prefixes on the younger instruction, and a branch in the older position. When pairing is refused, the older instruction issues alone. The younger one stays in the buffer and becomes the older slot in the next clock.

Each slot is described by a compact descriptor. It holds a valid bit, a 2-bit class, source and destination masks over the eight general registers plus the flags, prefix flags, displacement-present and immediate-present bits, and a branch bit. The decision is held in a registered three-state issue machine with these states:
- `ST_IDLE`: nothing issues.
- `ST_SOLO`: the U pipe only.
- `ST_DUAL`: both pipes.

Every clock the machine takes one of these transitions, whatever state it is in:
- **none**: the older slot is empty, so the machine goes to `ST_IDLE`.
- **single**: the older slot is valid and pairing is refused or the younger slot is empty, so the machine goes to `ST_SOLO`.
- **pair**: the older slot is valid and pairing is allowed, so the machine goes to `ST_DUAL`.
- **hold**: stall is high and flush is low, so the machine stays in its current state.
- **flush**: flush is high, so the machine goes to `ST_IDLE`.

The issue outputs and the consumed count are decoded from the state. The buffer advances by the consumed count.

Top module: `pair_checker`

## Requirements
- R1: The outputs depend only on the state. `ST_IDLE` gives issue_u=0, issue_v=0 and consumed=0. `ST_SOLO` gives 1, 0 and 1. `ST_DUAL` gives 1, 1 and 2. An older slot that is not valid leads to `ST_IDLE`.
- R2: If the older slot is valid and the younger slot is not valid, the result is `ST_SOLO`. No pairing rule changes this.
- R3: Class codes are 00 not pairable, 01 pairs in either pipe, 10 pairs only as the older (U) instruction, and 11 pairs only as the younger (V) instruction. Pairing needs an older class of 01 or 10 and a younger class of 01 or 11.
- R4: Pairing is refused on read-after-write. This happens when the younger source mask (bits 0..7 general registers, bit 8 flags) overlaps the older destination mask in any of bits 0..8.
- R5: Pairing is refused on write-after-write. This happens when the two destination masks overlap in bits 0..7. An overlap in bit 8 (flags) alone does not refuse pairing.
- R6: Pairing is refused when either instruction has both the displacement-present bit and the immediate-present bit set.
- R7: Prefix bit 0 marks the two-byte opcode escape, and bits 1..3 mark other prefixes. Pairing is refused when the younger instruction has any of bits 1..3 set. Prefix bits on the older instruction, and bit 0 on the younger, have no effect.
- R8: Pairing is refused when the older instruction is a branch. A branch in the younger slot does not prevent pairing.
- R9: The decision is registered. Inputs sampled at a rising edge appear on the outputs just after that edge.
- R10: When stall is high and flush is low, all outputs keep their values across the edge.
- R11: When flush is high, the next state is `ST_IDLE`, even if stall is also high.
- R12: While reset is asserted (rst_n low), the outputs are 0, 0 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_stall | input | 1 | Hold the registered decision |
| i_flush | input | 1 | Clear the registered decision |
| i_old_valid | input | 1 | Older slot valid |
| i_old_cls | input | 2 | Older pairability class |
| i_old_src | input | 9 | Older source mask (bit 8 flags) |
| i_old_dst | input | 9 | Older destination mask (bit 8 flags) |
| i_old_pfx | input | 4 | Older prefix flags (bit 0 escape) |
| i_old_disp | input | 1 | Older has a displacement |
| i_old_imm | input | 1 | Older has an immediate |
| i_old_branch | input | 1 | Older is a branch |
| i_yng_valid | input | 1 | Younger slot valid |
| i_yng_cls | input | 2 | Younger pairability class |
| i_yng_src | input | 9 | Younger source mask (bit 8 flags) |
| i_yng_dst | input | 9 | Younger destination mask (bit 8 flags) |
| i_yng_pfx | input | 4 | Younger prefix flags (bit 0 escape) |
| i_yng_disp | input | 1 | Younger has a displacement |
| i_yng_imm | input | 1 | Younger has an immediate |
| i_yng_branch | input | 1 | Younger is a branch |
| o_issue_u | output | 1 | An instruction issues to the U pipe |
| o_issue_v | output | 1 | An instruction issues to the V pipe |
| o_consumed | output | 2 | Number of buffer entries consumed |

## Verification
The assertions assume that the descriptors are stable and fully defined at every rising edge, because they are checked one cycle later against the outputs. They also assume that a younger slot is only presented behind a valid older one, as the instruction buffer fills in order. The stimulus changes every input at the falling edge only. It always drives known values, and it keeps the younger slot valid only when the older one is valid, in both the directed cases and the random mix.

// File: rtl/pair_pkg.sv
package pair_pkg;

    localparam int unsigned NREG  = 8;
    localparam int unsigned MSK_W = NREG + 1;
    localparam int unsigned FLAG_BIT = NREG;
    localparam int unsigned PFX_W = 4;
    localparam int unsigned ESC_BIT = 0;

    typedef enum logic [1:0] {
        CLS_NP = 2'b00,
        CLS_UV = 2'b01,
        CLS_PU = 2'b10,
        CLS_PV = 2'b11
    } pclass_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_SOLO = 2'b01,
        ST_DUAL = 2'b10
    } iss_state_e;

endpackage

// File: rtl/pair_slot_ok.sv
module pair_slot_ok
    import pair_pkg::*;
#(
    parameter bit IS_YOUNG = 1'b0
) (
    input  logic [1:0] i_cls,
    input  logic       i_disp,
    input  logic       i_imm,
    input  logic       i_pos_block,
    output logic       o_ok
);

    logic cls_fits;
    logic dimm_clash;

    generate
        if (IS_YOUNG) begin : g_vslot
            always_comb begin
                unique case (pclass_e'(i_cls))
                    CLS_UV:  cls_fits = 1'b1;
                    CLS_PV:  cls_fits = 1'b1;
                    default: cls_fits = 1'b0;
                endcase
            end
        end else begin : g_uslot
            always_comb begin
                unique case (pclass_e'(i_cls))
                    CLS_UV:  cls_fits = 1'b1;
                    CLS_PU:  cls_fits = 1'b1;
                    default: cls_fits = 1'b0;
                endcase
            end
        end
    endgenerate

    assign dimm_clash = i_disp & i_imm;
    assign o_ok       = cls_fits & ~dimm_clash & ~i_pos_block;

endmodule

// File: rtl/pair_hazard.sv
module pair_hazard
    import pair_pkg::*;
#(
    parameter int unsigned N_GPR = NREG
) (
    input  logic [N_GPR:0] i_old_dst,
    input  logic [N_GPR:0] i_yng_src,
    input  logic [N_GPR:0] i_yng_dst,
    output logic           o_raw,
    output logic           o_waw,
    output logic           o_hazard
);

    localparam int unsigned W = N_GPR + 1;

    logic [W-1:0]     raw_bits;
    logic [N_GPR-1:0] waw_bits;

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_raw
            assign raw_bits[b] = i_yng_src[b] & i_old_dst[b];
        end
        for (b = 0; b < N_GPR; b++) begin : g_waw
            assign waw_bits[b] = i_yng_dst[b] & i_old_dst[b];
        end
    endgenerate

    assign o_raw    = |raw_bits;
    assign o_waw    = |waw_bits;
    assign o_hazard = o_raw | o_waw;

endmodule

// File: rtl/pair_issue_fsm.sv
module pair_issue_fsm
    import pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       i_stall,
    input  logic       i_flush,
    input  logic       i_old_valid,
    input  logic       i_pair_ok,
    output logic       o_issue_u,
    output logic       o_issue_v,
    output logic [1:0] o_consumed
);

    iss_state_e state_q;
    iss_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (i_flush) begin
            state_d = ST_IDLE;
        end else if (!i_stall) begin
            if (!i_old_valid) begin
                state_d = ST_IDLE;
            end else if (i_pair_ok) begin
                state_d = ST_DUAL;
            end else begin
                state_d = ST_SOLO;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        o_issue_u  = 1'b0;
        o_issue_v  = 1'b0;
        o_consumed = 2'd0;
        unique case (state_q)
            ST_IDLE: begin
                o_issue_u  = 1'b0;
                o_issue_v  = 1'b0;
                o_consumed = 2'd0;
            end
            ST_SOLO: begin
                o_issue_u  = 1'b1;
                o_issue_v  = 1'b0;
                o_consumed = 2'd1;
            end
            ST_DUAL: begin
                o_issue_u  = 1'b1;
                o_issue_v  = 1'b1;
                o_consumed = 2'd2;
            end
            default: begin
                o_issue_u  = 1'b0;
                o_issue_v  = 1'b0;
                o_consumed = 2'd0;
            end
        endcase
    end

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        i_flush |=> (!o_issue_u && !o_issue_v && o_consumed == 2'd0)); // R11

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (i_stall && !i_flush) |=> ($stable(o_issue_u) && $stable(o_issue_v) && $stable(o_consumed))); // R10

    AST_V_NEEDS_U: assert property (@(posedge clk) disable iff (!rst_n)
        o_issue_v |-> o_issue_u); // R1

    AST_NO_OLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_stall && !i_flush && !i_old_valid) |=> (o_consumed == 2'd0)); // R1

endmodule

// File: rtl/pair_checker.sv
module pair_checker
    import pair_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_stall,
    input  logic             i_flush,
    input  logic             i_old_valid,
    input  logic [1:0]       i_old_cls,
    input  logic [MSK_W-1:0] i_old_src,
    input  logic [MSK_W-1:0] i_old_dst,
    input  logic [PFX_W-1:0] i_old_pfx,
    input  logic             i_old_disp,
    input  logic             i_old_imm,
    input  logic             i_old_branch,
    input  logic             i_yng_valid,
    input  logic [1:0]       i_yng_cls,
    input  logic [MSK_W-1:0] i_yng_src,
    input  logic [MSK_W-1:0] i_yng_dst,
    input  logic [PFX_W-1:0] i_yng_pfx,
    input  logic             i_yng_disp,
    input  logic             i_yng_imm,
    input  logic             i_yng_branch,
    output logic             o_issue_u,
    output logic             o_issue_v,
    output logic [1:0]       o_consumed
);

    localparam logic [PFX_W-1:0] ESC_MASK = PFX_W'(1) << ESC_BIT;

    logic old_slot_ok;
    logic yng_slot_ok;
    logic yng_pfx_block;
    logic raw_hit;
    logic waw_hit;
    logic reg_hazard;
    logic pair_ok;

    assign yng_pfx_block = |(i_yng_pfx & ~ESC_MASK);

    pair_slot_ok #(.IS_YOUNG(1'b0)) u_old_slot (
        .i_cls       (i_old_cls),
        .i_disp      (i_old_disp),
        .i_imm       (i_old_imm),
        .i_pos_block (i_old_branch),
        .o_ok        (old_slot_ok)
    );

    pair_slot_ok #(.IS_YOUNG(1'b1)) u_yng_slot (
        .i_cls       (i_yng_cls),
        .i_disp      (i_yng_disp),
        .i_imm       (i_yng_imm),
        .i_pos_block (yng_pfx_block),
        .o_ok        (yng_slot_ok)
    );

    pair_hazard #(.N_GPR(NREG)) u_hazard (
        .i_old_dst (i_old_dst),
        .i_yng_src (i_yng_src),
        .i_yng_dst (i_yng_dst),
        .o_raw     (raw_hit),
        .o_waw     (waw_hit),
        .o_hazard  (reg_hazard)
    );

    assign pair_ok = i_yng_valid & old_slot_ok & yng_slot_ok & ~reg_hazard;

    pair_issue_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .i_stall     (i_stall),
        .i_flush     (i_flush),
        .i_old_valid (i_old_valid),
        .i_pair_ok   (pair_ok),
        .o_issue_u   (o_issue_u),
        .o_issue_v   (o_issue_v),
        .o_consumed  (o_consumed)
    );

    AST_EMPTY_YNG_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_stall && !i_flush && i_old_valid && !i_yng_valid) |=> (o_issue_u && !o_issue_v)); // R2

    AST_RAW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_stall && !i_flush && raw_hit) |=> !o_issue_v); // R4

    AST_WAW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_stall && !i_flush && waw_hit) |=> !o_issue_v); // R5

    AST_NP_NEVER_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_stall && !i_flush && (i_old_cls == CLS_NP || i_yng_cls == CLS_NP)) |=> !o_issue_v); // R3

    AST_DIMM_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_stall && !i_flush && ((i_old_disp && i_old_imm) || (i_yng_disp && i_yng_imm))) |=> !o_issue_v); // R6

    AST_OLD_BR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_stall && !i_flush && i_old_branch) |=> !o_issue_v); // R8

    AST_YNG_PFX_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_stall && !i_flush && (|i_yng_pfx[PFX_W-1:1])) |=> !o_issue_v); // R7

    AST_OLD_PFX_STILL_U: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_stall && !i_flush && i_old_valid && (|i_old_pfx)) |=> o_issue_u); // R7

    AST_YNG_BR_KEEPS_U: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_stall && !i_flush && i_old_valid && i_yng_branch) |=> o_issue_u); // R8

endmodule

// File: tb/test_pair_checker.sv
`timescale 1ns/1ps
module test_pair_checker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stall = 1'b0, flush = 1'b0;
    logic       ov, yv;
    logic [1:0] oc, yc;
    logic [8:0] osrc, odst, ysrc, ydst;
    logic [3:0] opfx, ypfx;
    logic       odsp, oimm, obr, ydsp, yimm, ybr;
    logic       iu, iv;
    logic [1:0] cnt;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic       u;
        logic       v;
        logic [1:0] c;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    logic       last_u = 1'b0, last_v = 1'b0;
    logic [1:0] last_c = 2'd0;

    always #4 clk = ~clk;

    pair_checker i_pair_checker (
        .clk(clk), .rst_n(rst_n), .i_stall(stall), .i_flush(flush),
        .i_old_valid(ov), .i_old_cls(oc), .i_old_src(osrc), .i_old_dst(odst),
        .i_old_pfx(opfx), .i_old_disp(odsp), .i_old_imm(oimm), .i_old_branch(obr),
        .i_yng_valid(yv), .i_yng_cls(yc), .i_yng_src(ysrc), .i_yng_dst(ydst),
        .i_yng_pfx(ypfx), .i_yng_disp(ydsp), .i_yng_imm(yimm), .i_yng_branch(ybr),
        .o_issue_u(iu), .o_issue_v(iv), .o_consumed(cnt)
    );

    task automatic check(input string tag, input logic u, input logic v, input logic [1:0] c);
        checks++;
        if (iu !== u || iv !== v || cnt !== c) begin
            fails++;
            $display("FAIL %s: got u=%b v=%b cnt=%0d expected u=%b v=%b cnt=%0d",
                     tag, iu, iv, cnt, u, v, c);
        end
    endtask

    task automatic base();
        ov = 1; oc = 2'b01; osrc = 9'h001; odst = 9'h002; opfx = 0; odsp = 0; oimm = 0; obr = 0;
        yv = 1; yc = 2'b01; ysrc = 9'h004; ydst = 9'h008; ypfx = 0; ydsp = 0; yimm = 0; ybr = 0;
    endtask

    function automatic logic can_pair();
        logic ok;
        ok = (oc == 2'b01 || oc == 2'b10) && (yc == 2'b01 || yc == 2'b11);
        ok = ok && !(odsp && oimm) && !(ydsp && yimm) && !obr;
        ok = ok && (ypfx[3:1] == 3'b000);
        ok = ok && ((ysrc & odst) == 9'h000) && ((ydst[7:0] & odst[7:0]) == 8'h00);
        return ok;
    endfunction

    // Drive at falling edge; expected result appears after the next rising edge (R9).
    task automatic step(input string tag, input logic st, input logic fl);
        exp_t e;
        stall = st;
        flush = fl;
        if (fl) begin
            e.u = 0; e.v = 0; e.c = 0;
        end else if (st) begin
            e.u = last_u; e.v = last_v; e.c = last_c;
        end else if (!ov) begin
            e.u = 0; e.v = 0; e.c = 0;
        end else if (!yv || !can_pair()) begin
            e.u = 1; e.v = 0; e.c = 1;
        end else begin
            e.u = 1; e.v = 1; e.c = 2;
        end
        e.tag = tag;
        last_u = e.u; last_v = e.v; last_c = e.c;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, e.u, e.v, e.c);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        base();
        repeat (3) @(negedge clk);
        check("R12 reset", 0, 0, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);

        base(); step("R1 dual pair", 0, 0);
        base(); ov = 0; yv = 0; step("R1 older invalid", 0, 0);
        base(); yv = 0; ysrc = 9'h002; yc = 2'b00; step("R2 younger empty", 0, 0);
        base(); oc = 2'b00; step("R3 older NP", 0, 0);
        base(); oc = 2'b10; yc = 2'b11; step("R3 PU+PV pair", 0, 0);
        base(); oc = 2'b11; step("R3 older PV", 0, 0);
        base(); yc = 2'b10; step("R3 younger PU", 0, 0);
        base(); ysrc = 9'h002; step("R4 raw gpr", 0, 0);
        base(); odst = 9'h100; ysrc = 9'h100; step("R4 raw flags", 0, 0);
        base(); ydst = 9'h002; step("R5 waw gpr", 0, 0);
        base(); odst = 9'h102; ydst = 9'h108; step("R5 flags-only waw pairs", 0, 0);
        base(); odsp = 1; oimm = 1; step("R6 older disp+imm", 0, 0);
        base(); ydsp = 1; yimm = 1; step("R6 younger disp+imm", 0, 0);
        base(); odsp = 1; yimm = 1; step("R6 split disp/imm pairs", 0, 0);
        base(); ypfx = 4'b0100; step("R7 younger prefix", 0, 0);
        base(); ypfx = 4'b0001; step("R7 younger escape pairs", 0, 0);
        base(); opfx = 4'b1110; step("R7 older prefix pairs", 0, 0);
        base(); obr = 1; step("R8 older branch", 0, 0);
        base(); ybr = 1; step("R8 younger branch pairs", 0, 0);
        base(); step("R9 pair", 0, 0);
        base(); yv = 0; step("R9 solo next", 0, 0);
        base(); step("R10 setup", 0, 0);
        base(); ov = 0; yv = 0; step("R10 stall holds", 1, 0);
        base(); obr = 1; step("R10 stall holds again", 1, 0);
        base(); step("R11 flush over stall", 1, 1);
        base(); step("R11 flush", 0, 1);
        base(); step("R11 recover", 0, 0);

        for (int i = 0; i < 400; i++) begin
            ov = 1'($urandom); oc = 2'($urandom);
            osrc = 9'($urandom); odst = 9'($urandom) & 9'($urandom);
            opfx = 4'($urandom) & 4'($urandom); odsp = 1'($urandom); oimm = 1'($urandom);
            obr = ($urandom % 4) == 0;
            yv = ov & 1'($urandom); yc = 2'($urandom);
            ysrc = 9'($urandom) & 9'($urandom); ydst = 9'($urandom) & 9'($urandom);
            ypfx = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
            ydsp = 1'($urandom); yimm = 1'($urandom); ybr = 1'($urandom);
            step("R9 random mix", ($urandom % 8) == 0, ($urandom % 16) == 0);
        end

        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule